// File: doc/BRIEF.md
# ATA Task-File PIO Sector Engine

This block is the device side of a disk's task-file register set. A host bus writes the sector-count, sector, cylinder-low, cylinder-high and select registers, then writes a command code to the status/command address. A PIO sector read builds a 28-bit logical block address from those registers. For each sector it pulls 256 sixteen-bit words from a synchronous sector-memory port into an internal buffer, then hands the words out one at a time through the data register.

The status register reports BSY, DRQ and ERR, with the ready bit forced on. An interrupt request pulse marks each sector that becomes available. Commands that carry no data hold BSY for a parameterised number of clock cycles, then finish with one interrupt pulse. Malformed or unknown commands fail at once through ERR and the error register.

Top module: `ata_taskfile_engine`

## Requirements
- R1: After reset the status address (7) reads 0x0040, the error register (address 1) reads 0x00, `irq` is low, and the task-file registers read 0x00.
- R2: Addresses 2 (sector count), 3 (sector), 4 (cylinder low), 5 (cylinder high) and 6 (select) read back the last byte written to them. The error register at address 1 cannot be written from the host.
- R3: A command written to address 7 while BSY is clear is accepted. It clears the error register, ERR and DRQ. For a delayed command, BSY (status bit 7) reads 1 from the cycle after the write, so the status reads 0xC0.
- R4: The non-data commands 0x10, 0x91, 0xE3, 0xE7 and 0xEF keep BSY set for exactly BUSY_CYCLES clock cycles. On the edge where BSY clears, `irq` rises for exactly one cycle, and DRQ is never set.
- R5: Command 0x20 (read sectors) with select bit 6 clear fails at once. Status reads 0x41 (ERR = bit 0), the error register reads 0x01, BSY is never set and no `irq` is raised.
- R6: A sector read fetches memory word address {LBA, word index} with index 0..255 in order. LBA = {select[3:0], cylinder high, cylinder low, sector}. Each further sector uses LBA+1, wrapping modulo 2^28.
- R7: When a sector is buffered, status reads 0x48 (DRQ = bit 3, BSY clear) and `irq` pulses for one cycle. Each read of address 0 returns the next buffered word, in index order. DRQ clears after the 256th read.
- R8: After a sector is drained, if sectors remain, BSY is set again and the next sector follows the same sequence. After the last one, status reads 0x40. A sector count of 0 means 256 sectors.
- R9: An unrecognised command code sets ERR (status 0x41) and writes 0x01 to the error register, with no BSY and no `irq`.
- R10: A command written while BSY is set is ignored. The running command finishes at its original time and its error state is unchanged.
- R11: With select bit 4 set, the status address reads 0x0001. The alternate-status address (8) always reads 0x0040.
- R12: Command 0x00 completes at once. It clears ERR and the error register without setting BSY or raising `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 4 | Host write register address |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host read strobe; a read of address 0 consumes a data word |
| rd_addr | input | 4 | Host read register address |
| rd_data | output | 16 | Read value for rd_addr (combinational) |
| mem_rd_en | output | 1 | Sector-memory read request |
| mem_addr | output | 36 | Sector-memory word address {LBA, word index} |
| mem_rdata | input | 16 | Sector-memory word, valid the cycle after the request |
| irq | output | 1 | One-cycle interrupt request pulse |

## Verification
The assertions take for granted that the sector memory returns each word exactly one cycle after its request, and that BUSY_CYCLES is at least one. They also assume the host removes a data word only by reading address 0 while DRQ is set. The stimulus keeps within this: the memory model is a single registered stage, and writes and reads are driven on the falling edge, one register access per cycle. Data reads are issued only after the per-sector interrupt has been seen. A command is sent during BSY only in the test that checks it is ignored.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the task-file sector engine.
// Assumes a 28-bit LBA and 512-byte sectors carried as 16-bit words.
package ata_tf_pkg;
    localparam int LBA_W    = 28;
    localparam int WORD_AW  = 8;
    localparam int DATA_W   = 16;
    localparam int REM_W    = 9;
    localparam int REG_AW   = 4;
    localparam int TF_REGS  = 5;

    localparam logic [REG_AW-1:0] ADDR_DATA  = 4'd0;
    localparam logic [REG_AW-1:0] ADDR_ERR   = 4'd1;
    localparam logic [REG_AW-1:0] ADDR_CNT   = 4'd2;
    localparam logic [REG_AW-1:0] ADDR_STCMD = 4'd7;
    localparam logic [REG_AW-1:0] ADDR_ALT   = 4'd8;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_FETCH, SQ_XFER} seq_state_t;
    typedef enum logic [1:0] {CK_BAD, CK_NOP, CK_NODATA, CK_READ} cmd_kind_t;

    // Map a command byte onto the handling class it belongs to.
    function automatic cmd_kind_t classify(input logic [7:0] code);
        case (code)
            8'h00:                             return CK_NOP;
            8'h20:                             return CK_READ;
            8'h10, 8'h91, 8'hE3, 8'hE7, 8'hEF: return CK_NODATA;
            default:                           return CK_BAD;
        endcase
    endfunction
endpackage

// File: rtl/ata_tf_regs.sv
`timescale 1ns/1ps
// Host-writable task-file byte registers (count, sector, cyl-lo, cyl-hi, select).
// Assumes one write per cycle. Slot g lives at address ADDR_CNT+g.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_AW-1:0]           wr_addr,
    input  logic [7:0]                  wr_data,
    output logic [TF_REGS-1:0][7:0]     tf_q
);
    for (genvar g = 0; g < TF_REGS; g++) begin : g_tf
        localparam logic [REG_AW-1:0] MY_ADDR = ADDR_CNT + REG_AW'(g);
        // Capture a host byte aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tf_q[g] <= 8'h00;
            else if (wr_en && wr_addr == MY_ADDR)
                tf_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/ata_tf_seq.sv
`timescale 1ns/1ps
// Command sequencer: decodes commands and owns BSY/DRQ/ERR, the error code,
// the current LBA, the sectors remaining and the interrupt pulse.
// Assumes BUSY_CYCLES >= 1 and that the fetch unit raises fetch_done once per start.
module ata_tf_seq
    import ata_tf_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_code,
    input  logic             lba_mode,
    input  logic [LBA_W-1:0] lba_in,
    input  logic [7:0]       count_in,
    input  logic             pop_last,
    input  logic             fetch_done,
    output logic             busy,
    output logic             drq,
    output logic             err,
    output logic [7:0]       err_code,
    output logic             irq,
    output logic             fetch_start,
    output logic [LBA_W-1:0] lba
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LAST_TICK = CW'(BUSY_CYCLES - 1);
    localparam logic [REM_W-1:0] FULL_RUN = {1'b1, {(REM_W-1){1'b0}}};

    seq_state_t       state_q;
    logic [CW-1:0]    cnt_q;
    logic [REM_W-1:0] remain_q;
    logic             read_q;
    logic             accept;
    logic             wait_end;

    assign busy        = (state_q == SQ_WAIT) || (state_q == SQ_FETCH);
    assign drq         = (state_q == SQ_XFER);
    assign accept      = cmd_wr && !busy;
    assign wait_end    = (state_q == SQ_WAIT) && (cnt_q == LAST_TICK);
    assign fetch_start = wait_end && read_q;

    // Command launch, busy countdown, per-sector hand-off and chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            cnt_q    <= '0;
            remain_q <= '0;
            read_q   <= 1'b0;
            lba      <= '0;
            err      <= 1'b0;
            err_code <= 8'h00;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (accept) begin
                err      <= 1'b0;
                err_code <= 8'h00;
                cnt_q    <= '0;
                case (classify(cmd_code))
                    CK_NOP:    state_q <= SQ_IDLE;
                    CK_NODATA: begin
                        state_q <= SQ_WAIT;
                        read_q  <= 1'b0;
                    end
                    CK_READ: begin
                        if (lba_mode) begin
                            state_q  <= SQ_WAIT;
                            read_q   <= 1'b1;
                            lba      <= lba_in;
                            remain_q <= (count_in == 8'h00) ? FULL_RUN : {1'b0, count_in};
                        end else begin
                            state_q  <= SQ_IDLE;
                            err      <= 1'b1;
                            err_code <= 8'h01;
                        end
                    end
                    default: begin
                        state_q  <= SQ_IDLE;
                        err      <= 1'b1;
                        err_code <= 8'h01;
                    end
                endcase
            end else begin
                case (state_q)
                    SQ_WAIT: begin
                        if (wait_end) begin
                            if (read_q) begin
                                state_q <= SQ_FETCH;
                            end else begin
                                state_q <= SQ_IDLE;
                                irq     <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    SQ_FETCH: begin
                        if (fetch_done) begin
                            state_q  <= SQ_XFER;
                            irq      <= 1'b1;
                            lba      <= lba + 1'b1;
                            remain_q <= remain_q - 1'b1;
                        end
                    end
                    SQ_XFER: begin
                        if (pop_last) begin
                            cnt_q   <= '0;
                            state_q <= (remain_q != '0) ? SQ_WAIT : SQ_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4
    irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R5
    err_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);
    // R10
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !wait_end && !(state_q == SQ_FETCH && fetch_done)) |=> busy);
endmodule

// File: rtl/ata_tf_fetch.sv
`timescale 1ns/1ps
// Sector fetch unit: walks word indices 0..WORDS-1 of one sector on the memory
// port and streams the returned words into the buffer write port.
// Assumes memory data arrives exactly one cycle after each request.
module ata_tf_fetch
    import ata_tf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LBA_W-1:0]         lba,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     mem_rd_en,
    output logic [LBA_W+WORD_AW-1:0] mem_addr,
    output logic                     buf_we,
    output logic [WORD_AW-1:0]       buf_widx,
    output logic [DATA_W-1:0]        buf_wdata,
    output logic                     done
);
    localparam int MEM_AW = LBA_W + WORD_AW;

    logic               active_q;
    logic [WORD_AW:0]   fidx_q;
    logic               valid_q;
    logic [WORD_AW-1:0] widx_q;

    assign mem_rd_en = active_q && !fidx_q[WORD_AW];
    assign mem_addr  = {lba, fidx_q[WORD_AW-1:0]};
    assign done      = active_q && fidx_q[WORD_AW] && !valid_q;
    assign buf_we    = valid_q;
    assign buf_widx  = widx_q;
    assign buf_wdata = mem_rdata;

    // Issue requests in index order and track which response is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            fidx_q   <= '0;
            valid_q  <= 1'b0;
            widx_q   <= '0;
        end else begin
            valid_q <= mem_rd_en;
            if (mem_rd_en)
                widx_q <= fidx_q[WORD_AW-1:0];
            if (start) begin
                active_q <= 1'b1;
                fidx_q   <= '0;
            end else if (done) begin
                active_q <= 1'b0;
            end else if (mem_rd_en) begin
                fidx_q <= fidx_q + 1'b1;
            end
        end
    end

    // R6
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + MEM_AW'(1)));
endmodule

// File: rtl/ata_tf_buffer.sv
`timescale 1ns/1ps
// One-sector word buffer: filled by the fetch unit, drained in index order by
// host data reads. Assumes fill and drain never overlap.
module ata_tf_buffer
    import ata_tf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rewind,
    input  logic               we,
    input  logic [WORD_AW-1:0] widx,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               pop,
    output logic [DATA_W-1:0]  rdata,
    output logic               last
);
    localparam int WORDS = 1 << WORD_AW;

    logic [DATA_W-1:0]  mem_q [WORDS];
    logic [WORD_AW-1:0] ridx_q;

    assign rdata = mem_q[ridx_q];
    assign last  = (ridx_q == WORD_AW'(WORDS - 1));

    // Store one fetched word.
    always_ff @(posedge clk) begin
        if (we)
            mem_q[widx] <= wdata;
    end

    // Move the read pointer: back to zero for a new sector, forward on a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ridx_q <= '0;
        else if (rewind)
            ridx_q <= '0;
        else if (pop)
            ridx_q <= ridx_q + 1'b1;
    end
endmodule

// File: rtl/ata_taskfile_engine.sv
`timescale 1ns/1ps
// Top of the task-file PIO sector engine: host register decode, read mux,
// and wiring of registers, sequencer, fetch unit and sector buffer.
// Assumes one host access per cycle and a one-cycle-latency sector memory.
module ata_taskfile_engine
    import ata_tf_pkg::*;
#(
    parameter int BUSY_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [3:0]               wr_addr,
    input  logic [7:0]               wr_data,
    input  logic                     rd_en,
    input  logic [3:0]               rd_addr,
    output logic [15:0]              rd_data,
    output logic                     mem_rd_en,
    output logic [35:0]              mem_addr,
    input  logic [15:0]              mem_rdata,
    output logic                     irq
);
    logic [TF_REGS-1:0][7:0] tf_q;
    logic [7:0]              sel_q;
    logic [LBA_W-1:0]        lba_asm;
    logic [LBA_W-1:0]        lba_cur;
    logic                    cmd_wr, busy, drq, err, pop, pop_last;
    logic [7:0]              err_code;
    logic                    fetch_start, fetch_done;
    logic                    buf_we, buf_last;
    logic [WORD_AW-1:0]      buf_widx;
    logic [DATA_W-1:0]       buf_wdata, buf_rdata;
    logic [7:0]              status_b;

    assign sel_q    = tf_q[4];
    assign lba_asm  = {sel_q[3:0], tf_q[3], tf_q[2], tf_q[1]};
    assign cmd_wr   = wr_en && (wr_addr == ADDR_STCMD);
    assign pop      = rd_en && (rd_addr == ADDR_DATA) && drq;
    assign pop_last = pop && buf_last;
    assign status_b = {busy, 1'b1, 2'b00, drq, 2'b00, err};

    ata_tf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tf_q(tf_q)
    );

    ata_tf_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(wr_data),
        .lba_mode(sel_q[6]), .lba_in(lba_asm), .count_in(tf_q[0]),
        .pop_last(pop_last), .fetch_done(fetch_done), .busy(busy), .drq(drq),
        .err(err), .err_code(err_code), .irq(irq), .fetch_start(fetch_start),
        .lba(lba_cur)
    );

    ata_tf_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .start(fetch_start), .lba(lba_cur),
        .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .buf_we(buf_we), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
        .done(fetch_done)
    );

    ata_tf_buffer u_buf (
        .clk(clk), .rst_n(rst_n), .rewind(fetch_start), .we(buf_we),
        .widx(buf_widx), .wdata(buf_wdata), .pop(pop), .rdata(buf_rdata),
        .last(buf_last)
    );

    // Host read mux over data, error, task-file bytes, status and alt-status.
    always_comb begin
        rd_data = 16'h0000;
        case (rd_addr)
            ADDR_DATA:  rd_data = drq ? buf_rdata : 16'h0000;
            ADDR_ERR:   rd_data = {8'h00, err_code};
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6:
                        rd_data = {8'h00, tf_q[rd_addr - ADDR_CNT]};
            ADDR_STCMD: rd_data = sel_q[4] ? 16'h0001 : {8'h00, status_b};
            ADDR_ALT:   rd_data = 16'h0040;
            default:    rd_data = 16'h0000;
        endcase
    end

    // R7
    drq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> ($past(pop) || $past(cmd_wr)));
    // R6
    fetch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> busy);
endmodule

// File: tb/tb_ata_taskfile_engine.sv
`timescale 1ns/1ps
module tb_ata_taskfile_engine;
    localparam int BUSY = 8;
    localparam int EX_NODATA = 0, EX_ERR = 1, EX_READ = 2, EX_NOP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = 4'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = 4'd7;
    logic [15:0] rd_data;
    logic        mem_rd_en;
    logic [35:0] mem_addr;
    logic [15:0] mem_rdata = 16'h0;
    logic        irq;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    ata_taskfile_engine #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] mword(input logic [35:0] a);
        return a[15:0] ^ {a[35:28], a[27:20]} ^ 16'h5A3C;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mword(mem_addr);

    // {kind, cmd, sel, cyl_hi, cyl_lo, sector, count}
    localparam logic [49:0] VEC [10] = '{
        {2'd0, 8'h10, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h01},
        {2'd0, 8'hE7, 8'hA0, 8'h12, 8'h34, 8'h56, 8'h00},
        {2'd1, 8'h20, 8'h0F, 8'h01, 8'h02, 8'h03, 8'h01},
        {2'd1, 8'h55, 8'h40, 8'h00, 8'h00, 8'h00, 8'h01},
        {2'd3, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 8'h01},
        {2'd2, 8'h20, 8'h45, 8'h33, 8'h22, 8'h11, 8'h01},
        {2'd2, 8'h20, 8'h4F, 8'hFF, 8'hFF, 8'hFF, 8'h02},
        {2'd0, 8'h91, 8'h40, 8'h00, 8'h00, 8'h00, 8'h03},
        {2'd0, 8'hEF, 8'h40, 8'h00, 8'h00, 8'h00, 8'h03},
        {2'd0, 8'hE3, 8'h40, 8'h00, 8'h00, 8'h00, 8'h03}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #0.1;
        v = rd_data;
    endtask

    task automatic nodata_check(input string tag);
        logic [15:0] v;
        int c0;
        bit seen = 0;
        c0 = cyc;
        peek(4'd7, v);
        chk(v == 16'h00C0, {tag, " R3 busy after command"}, v, 16'h00C0);
        for (int i = 0; i < 200 && !seen; i++) begin
            if (irq) seen = 1; else @(negedge clk);
        end
        chk(seen && (cyc - c0 == BUSY), {tag, " R4 irq after BUSY_CYCLES"}, cyc - c0, BUSY);
        peek(4'd7, v);
        chk(v == 16'h0040, {tag, " R4 status at completion"}, v, 16'h0040);
        @(negedge clk);
        chk(irq == 1'b0, {tag, " R4 irq one cycle"}, irq, 0);
    endtask

    task automatic fail_check(input string tag, input logic [7:0] exp_st);
        logic [15:0] v;
        bit bad = 0;
        peek(4'd7, v);
        chk(v == {8'h00, exp_st}, {tag, " status"}, v, exp_st);
        peek(4'd1, v);
        chk(v == ((exp_st[0]) ? 16'h0001 : 16'h0000), {tag, " error register"}, v,
            (exp_st[0]) ? 16'h0001 : 16'h0000);
        for (int i = 0; i < BUSY + 4; i++) begin
            peek(4'd7, v);
            if (irq || v[7]) bad = 1;
            @(negedge clk);
        end
        chk(!bad, {tag, " no busy and no irq"}, bad, 0);
    endtask

    task automatic run_read(input logic [27:0] lba, input int n, input string tag);
        logic [15:0] v;
        for (int s = 0; s < n; s++) begin
            logic [27:0] l;
            bit seen = 0;
            bit ok = 1;
            logic [15:0] bad_act = 0, bad_exp = 0;
            l = lba + 28'(s);
            for (int i = 0; i < 2000 && !seen; i++) begin
                if (irq) seen = 1; else @(negedge clk);
            end
            peek(4'd7, v);
            if (s == 0 || !seen || v != 16'h0048)
                chk(seen && v == 16'h0048, {tag, " R7 sector ready status"}, v, 16'h0048);
            for (int w = 0; w < 256; w++) begin
                logic [15:0] e;
                e = mword({l, 8'(w)});
                rd_en = 1'b1; rd_addr = 4'd0;
                #0.1;
                if (ok && rd_data != e) begin
                    ok = 0; bad_act = rd_data; bad_exp = e;
                end
                @(negedge clk);
            end
            rd_en = 1'b0;
            if (s == 0 || s == n - 1 || !ok)
                chk(ok, {tag, " R6 R7 sector words at LBA+k"}, bad_act, bad_exp);
            peek(4'd7, v);
            if (s == n - 1)
                chk(v == 16'h0040, {tag, " R8 idle after last sector"}, v, 16'h0040);
            else if (s == 0 || v != 16'h00C0)
                chk(v == 16'h00C0, {tag, " R8 busy for next sector"}, v, 16'h00C0);
        end
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(4'd7, v); chk(v == 16'h0040, "R1 status after reset", v, 16'h0040);
        peek(4'd1, v); chk(v == 16'h0000, "R1 error after reset", v, 0);
        peek(4'd2, v); chk(v == 16'h0000, "R1 count after reset", v, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);

        // R2 readback and read-only error register
        for (int a = 2; a <= 6; a++) wr(4'(a), 8'(8'h81 + a * 8'h11));
        for (int a = 2; a <= 6; a++) begin
            peek(4'(a), v);
            chk(v == {8'h00, 8'(8'h81 + a * 8'h11)}, "R2 task-file readback", v, 8'(8'h81 + a * 8'h11));
        end
        wr(4'd1, 8'h77);
        peek(4'd1, v); chk(v == 16'h0000, "R2 error register not writable", v, 0);

        // R11 device-1 status and alternate status
        wr(4'd6, 8'h10);
        peek(4'd7, v); chk(v == 16'h0001, "R11 device 1 status", v, 16'h0001);
        peek(4'd8, v); chk(v == 16'h0040, "R11 alternate status", v, 16'h0040);
        wr(4'd6, 8'h00);
        peek(4'd7, v); chk(v == 16'h0040, "R11 device 0 status", v, 16'h0040);

        // Vector table
        foreach (VEC[i]) begin
            logic [49:0] e;
            e = VEC[i];
            wr(4'd2, e[7:0]); wr(4'd3, e[15:8]); wr(4'd4, e[23:16]);
            wr(4'd5, e[31:24]); wr(4'd6, e[39:32]);
            wr(4'd7, e[47:40]);
            case (int'(e[49:48]))
                EX_NODATA: nodata_check($sformatf("vec%0d", i));
                EX_ERR:    fail_check($sformatf("vec%0d %s", i, (e[47:40] == 8'h20) ? "R5" : "R9"), 8'h41);
                EX_NOP:    fail_check($sformatf("vec%0d R12", i), 8'h40);
                default:   run_read({e[35:32], e[31:24], e[23:16], e[15:8]},
                                    (e[7:0] == 0) ? 256 : int'(e[7:0]), $sformatf("vec%0d", i));
            endcase
        end

        // R10 command during BSY ignored
        wr(4'd7, 8'h10);
        wr(4'd7, 8'h55);
        begin
            int c0; bit seen = 0;
            c0 = cyc - 2;
            for (int i = 0; i < 200 && !seen; i++) begin
                if (irq) seen = 1; else @(negedge clk);
            end
            chk(seen && (cyc - c0 == BUSY), "R10 original completion time", cyc - c0, BUSY);
            peek(4'd1, v); chk(v == 16'h0000, "R10 error unchanged", v, 0);
            peek(4'd7, v); chk(v == 16'h0040, "R10 status clean", v, 16'h0040);
        end

        // R8 count of zero reads 256 sectors
        wr(4'd2, 8'h00); wr(4'd3, 8'h00); wr(4'd4, 8'h0F);
        wr(4'd5, 8'h00); wr(4'd6, 8'h40);
        wr(4'd7, 8'h20);
        run_read(28'h0000F00, 256, "R8 count0");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule